// File: doc/BRIEF.md
# Dual-Mode Parallel Peripheral Port

This block is the parallel I/O port of a processor. Its input strobe and its output strobe can each be set active or passive. An active strobe belongs to the processor. A passive strobe is driven by an external host, and the processor then behaves as a peripheral of that host. The port holds an input data register, an output data register, two buffer flags (input full and output empty), a status word built from those flags, and a control register. The control register selects the strobe modes and the two interrupt masks.

Three select pins change direction and meaning with the strobe modes:

- When both strobes are active, the three pins carry the port address.
- When either strobe is passive, pin 2 becomes an active-low chip enable.
- When the output strobe is passive, pin 1 becomes a data/status select.
- When both strobes are passive, pin 0 carries a combined ready flag.

Host strobes are synchronized to the core clock. An accepted strobe is detected on its falling edge. Each accepted strobe may raise a pending interrupt, which the core clears by acknowledging it.

Top module: `ppio_port`

## Requirements
- R1: After reset:
  - the control register reads 0x1800 (both strobes active, both masks clear);
  - the input-full flag is 0 and the output-empty flag is 1;
  - both pending interrupts are 0;
  - the bus is not driven.
- R2: With control bit 11 = 0 and the chip enable low, a falling edge on the input strobe has these effects:
  - the value on the bus is written into the input data register;
  - the input-full flag is set;
  - both effects are visible 3 clock edges after the strobe falls.
- R3: A core read of the input register (`core_in_rd`) clears the input-full flag.
- R4: With control bit 12 = 0, the chip enable low and the output strobe low, the port drives the bus.
  - With select pin 1 low, it drives the output data register.
  - An accepted read of this kind sets the output-empty flag.
  - A core write of the output register clears the output-empty flag and loads the register.
- R5: During a passive host read with select pin 1 high, the bus carries the status word: bit 0 = input-full, bit 1 = output-empty, the other bits 0. A status read leaves the output-empty flag unchanged.
- R6: While the chip enable (select pin 2 input) is high, a passive strobe has no effect:
  - no data capture;
  - no flag change;
  - no interrupt;
  - no bus drive.
- R7: A strobe whose control bit is 1 (active) is ignored as a host strobe.
- R8: When both strobes are active, all three select pins are outputs carrying `act_port_addr` (value 000 selects port 0).
- R9: Select pin directions:
  - pin 2 is an input when either strobe is passive;
  - pin 1 is an input when the output strobe is passive;
  - pin 0 is always an output.
- R10: When both strobes are passive, select pin 0 outputs input-full OR output-empty.
- R11: An accepted input strobe sets the input pending interrupt only if control bit 7 = 1. An accepted output strobe sets the output pending interrupt only if control bit 6 = 1.
- R12: A strobe held low produces exactly one event. An acknowledge clears the pending interrupt. A new event in the same cycle as an acknowledge leaves the interrupt pending.
- R13: When the output strobe is active, the bus is driven, with the output data register, only while `act_out_cycle` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write value |
| ctrl_q | output | 16 | Control register contents |
| core_in_rd | input | 1 | Core read of input register, clears input-full |
| core_in_data | output | DW | Input data register |
| core_out_we | input | 1 | Core write of output register |
| core_out_wdata | input | DW | Value for output register |
| ack_in | input | 1 | Clears input pending interrupt |
| ack_out | input | 1 | Clears output pending interrupt |
| irq_in | output | 1 | Input strobe interrupt pending |
| irq_out | output | 1 | Output strobe interrupt pending |
| in_full | output | 1 | Input buffer full flag |
| out_empty | output | 1 | Output buffer empty flag |
| act_out_cycle | input | 1 | Core active-mode output cycle in progress |
| act_port_addr | input | 3 | Port address for active mode |
| in_strb_n | input | 1 | Host input strobe, active low |
| out_strb_n | input | 1 | Host output strobe, active low |
| sel_ce_n | input | 1 | Select pin 2 as input: chip enable, active low |
| sel_stat | input | 1 | Select pin 1 as input: 1 = status, 0 = data |
| sel_out | output | 3 | Select pin output values |
| sel_oe | output | 3 | Select pin output enables |
| bus_in | input | DW | Parallel bus input value |
| bus_out | output | DW | Parallel bus output value |
| bus_oe | output | 1 | Parallel bus output enable |

## Verification
The bench targets four kinds of fault:

- **Chip-enable gating.** If a host strobe is not gated by the chip enable, the input register is overwritten and interrupts appear while the host addresses another device.
- **Data/status select polarity.** A swapped select returns the flags where data was expected. If a status read is allowed to set output-empty, the host loses track of unread data.
- **Long strobes.** A strobe held low for many cycles exposes level detection, which raises repeated events.
- **Acknowledge colliding with a new event.** An acknowledge landing in the same cycle as a new event exposes a clear-wins priority, which drops an interrupt.

In addition, the select pin directions are compared in all four mode combinations. A wrong table would make the port fight the host on a pin.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
    localparam int CTRL_W      = 16;
    localparam int CB_OUT_ACT  = 12;
    localparam int CB_IN_ACT   = 11;
    localparam int CB_MSK_IN   = 7;
    localparam int CB_MSK_OUT  = 6;
    localparam logic [CTRL_W-1:0] CTRL_RST = 16'h1800;
    localparam int STB_IN  = 0;
    localparam int STB_OUT = 1;
    localparam int NSTB    = 2;

    typedef struct packed {
        logic out_act;
        logic in_act;
        logic msk_in;
        logic msk_out;
    } ppio_mode_t;

    function automatic ppio_mode_t decode_ctrl(input logic [CTRL_W-1:0] c);
        ppio_mode_t m;
        m.out_act = c[CB_OUT_ACT];
        m.in_act  = c[CB_IN_ACT];
        m.msk_in  = c[CB_MSK_IN];
        m.msk_out = c[CB_MSK_OUT];
        return m;
    endfunction
endpackage

// File: rtl/ppio_strobe_det.sv
module ppio_strobe_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strb_n,
    output logic fall
);
    logic [SYNC_STAGES:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-1:0], strb_n};
    end

    assign fall = sync_q[SYNC_STAGES] & ~sync_q[SYNC_STAGES-1];

    // R12
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);
endmodule

// File: rtl/ppio_pinmux.sv
module ppio_pinmux
    import ppio_pkg::*;
(
    input  ppio_mode_t  mode,
    input  logic [2:0]  addr,
    input  logic        in_full,
    input  logic        out_empty,
    output logic [2:0]  sel_out,
    output logic [2:0]  sel_oe
);
    logic both_passive;
    assign both_passive = ~mode.in_act & ~mode.out_act;

    always_comb begin
        sel_oe[2]  = mode.in_act & mode.out_act;
        sel_oe[1]  = mode.out_act;
        sel_oe[0]  = 1'b1;
        sel_out[2] = addr[2];
        sel_out[1] = addr[1];
        sel_out[0] = both_passive ? (in_full | out_empty) : addr[0];
    end
endmodule

// File: rtl/ppio_port.sv
module ppio_port
    import ppio_pkg::*;
#(
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    input  logic              core_in_rd,
    output logic [DW-1:0]     core_in_data,
    input  logic              core_out_we,
    input  logic [DW-1:0]     core_out_wdata,
    input  logic              ack_in,
    input  logic              ack_out,
    output logic              irq_in,
    output logic              irq_out,
    output logic              in_full,
    output logic              out_empty,
    input  logic              act_out_cycle,
    input  logic [2:0]        act_port_addr,
    input  logic              in_strb_n,
    input  logic              out_strb_n,
    input  logic              sel_ce_n,
    input  logic              sel_stat,
    output logic [2:0]        sel_out,
    output logic [2:0]        sel_oe,
    input  logic [DW-1:0]     bus_in,
    output logic [DW-1:0]     bus_out,
    output logic              bus_oe
);
    localparam int STAT_PAD = DW - 2;

    ppio_mode_t     mode;
    logic [NSTB-1:0] strb_n_v;
    logic [NSTB-1:0] fall_v;
    logic           in_evt, out_evt, out_data_rd;
    logic [DW-1:0]  in_reg, out_reg, status_w;

    assign mode     = decode_ctrl(ctrl_q);
    assign strb_n_v[STB_IN]  = in_strb_n;
    assign strb_n_v[STB_OUT] = out_strb_n;

    for (genvar g = 0; g < NSTB; g++) begin : g_det
        ppio_strobe_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk(clk), .rst(rst), .strb_n(strb_n_v[g]), .fall(fall_v[g])
        );
    end

    assign in_evt      = fall_v[STB_IN]  & ~mode.in_act  & ~sel_ce_n;
    assign out_evt     = fall_v[STB_OUT] & ~mode.out_act & ~sel_ce_n;
    assign out_data_rd = out_evt & ~sel_stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= CTRL_RST;
            in_reg    <= '0;
            out_reg   <= '0;
            in_full   <= 1'b0;
            out_empty <= 1'b1;
            irq_in    <= 1'b0;
            irq_out   <= 1'b0;
        end else begin
            if (cfg_we) ctrl_q <= cfg_wdata;
            if (in_evt) begin
                in_reg  <= bus_in;
                in_full <= 1'b1;
            end else if (core_in_rd) begin
                in_full <= 1'b0;
            end
            if (core_out_we) out_reg <= core_out_wdata;
            if (out_data_rd)      out_empty <= 1'b1;
            else if (core_out_we) out_empty <= 1'b0;
            if (in_evt && mode.msk_in)        irq_in <= 1'b1;
            else if (ack_in)                  irq_in <= 1'b0;
            if (out_evt && mode.msk_out)      irq_out <= 1'b1;
            else if (ack_out)                 irq_out <= 1'b0;
        end
    end

    assign core_in_data = in_reg;
    assign status_w     = {{STAT_PAD{1'b0}}, out_empty, in_full};
    assign bus_oe  = mode.out_act ? act_out_cycle : (~sel_ce_n & ~out_strb_n);
    assign bus_out = (~mode.out_act & sel_stat) ? status_w : out_reg;

    ppio_pinmux u_mux (
        .mode(mode), .addr(act_port_addr), .in_full(in_full),
        .out_empty(out_empty), .sel_out(sel_out), .sel_oe(sel_oe)
    );

    // R6
    ce_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_full) |-> !$past(sel_ce_n));
    // R3
    in_clr_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(core_in_rd) && !$past(in_evt)) |-> !in_full);
    // R4
    obe_clr_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(core_out_we) && !$past(out_data_rd)) |-> !out_empty);
    // R11
    pend_mask_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_in) |-> $past(ctrl_q[CB_MSK_IN]));
    // R13
    bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && !act_out_cycle) |-> !out_strb_n);
endmodule

// File: tb/sim_ppio_port.sv
module sim_ppio_port;
    localparam int DW = 16;

    logic clk = 0, rst = 1;
    logic cfg_we = 0; logic [15:0] cfg_wdata = 0; logic [15:0] ctrl_q;
    logic core_in_rd = 0; logic [DW-1:0] core_in_data;
    logic core_out_we = 0; logic [DW-1:0] core_out_wdata = 0;
    logic ack_in = 0, ack_out = 0, irq_in, irq_out, in_full, out_empty;
    logic act_out_cycle = 0; logic [2:0] act_port_addr = 0;
    logic in_strb_n = 1, out_strb_n = 1, sel_ce_n = 0, sel_stat = 0;
    logic [2:0] sel_out, sel_oe;
    logic [DW-1:0] bus_in = 0, bus_out; logic bus_oe;

    int n_chk = 0, n_bad = 0;
    logic [15:0] m_ctrl; logic [DW-1:0] m_in, m_out;
    logic m_full, m_empty, m_pi, m_po;

    always #5 clk = ~clk;

    ppio_port #(.DW(DW)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_oe(input logic [15:0] c);
        return {c[12] & c[11], c[12], 1'b1};
    endfunction

    function automatic logic [2:0] exp_sel(input logic [15:0] c, input logic [2:0] a,
                                           input logic f, input logic e);
        return {a[2], a[1], (!c[12] && !c[11]) ? (f | e) : a[0]};
    endfunction

    task automatic check_all();
        chk("R2 in_full", in_full, m_full);
        chk("R4 out_empty", out_empty, m_empty);
        chk("R2 in data", core_in_data, m_in);
        chk("R11 irq_in", irq_in, m_pi);
        chk("R11 irq_out", irq_out, m_po);
        chk("R9 sel_oe", sel_oe, exp_oe(m_ctrl));
        chk("R8 R10 sel_out", sel_out & sel_oe,
            exp_sel(m_ctrl, act_port_addr, m_full, m_empty) & exp_oe(m_ctrl));
        chk("R13 bus idle", bus_oe, 0);
    endtask

    task automatic pulse_cfg(input logic [15:0] v);
        @(negedge clk); cfg_we = 1; cfg_wdata = v;
        @(negedge clk); cfg_we = 0; m_ctrl = v;
    endtask

    task automatic core_rd();
        @(negedge clk); core_in_rd = 1;
        @(negedge clk); core_in_rd = 0; m_full = 0;
    endtask

    task automatic core_wr(input logic [DW-1:0] d);
        @(negedge clk); core_out_we = 1; core_out_wdata = d;
        @(negedge clk); core_out_we = 0; m_out = d; m_empty = 0;
    endtask

    task automatic do_ack(input bit which);
        @(negedge clk); if (which) ack_out = 1; else ack_in = 1;
        @(negedge clk); ack_in = 0; ack_out = 0;
        if (which) m_po = 0; else m_pi = 0;
    endtask

    task automatic host_write(input logic [DW-1:0] d, input logic ce_n, input int hold);
        @(negedge clk); bus_in = d; sel_ce_n = ce_n; in_strb_n = 0;
        repeat (3 + hold) @(negedge clk);
        if (!m_ctrl[11] && !ce_n) begin
            m_in = d; m_full = 1;
            if (m_ctrl[7]) m_pi = 1;
        end
        in_strb_n = 1; repeat (3) @(negedge clk); sel_ce_n = 0;
    endtask

    task automatic host_read(input logic stat, input logic ce_n);
        logic [DW-1:0] exp_bus;
        logic exp_oe_b;
        @(negedge clk); sel_ce_n = ce_n; sel_stat = stat; out_strb_n = 0;
        #1;
        exp_oe_b = !m_ctrl[12] && !ce_n;
        exp_bus  = stat ? {{(DW-2){1'b0}}, m_empty, m_full} : m_out;
        chk("R4 R6 bus_oe on read", bus_oe, exp_oe_b);
        if (exp_oe_b) chk(stat ? "R5 status word" : "R4 data word", bus_out, exp_bus);
        repeat (3) @(negedge clk);
        if (!m_ctrl[12] && !ce_n) begin
            if (!stat) m_empty = 1;
            if (m_ctrl[6]) m_po = 1;
        end
        out_strb_n = 1; repeat (3) @(negedge clk); sel_ce_n = 0; sel_stat = 0;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'h5eed_1234));
        m_ctrl = 16'h1800; m_in = 0; m_out = 0; m_full = 0; m_empty = 1; m_pi = 0; m_po = 0;
        repeat (3) @(negedge clk); rst = 0; @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", ctrl_q, 16'h1800);
        chk("R1 in_full", in_full, 0);
        chk("R1 out_empty", out_empty, 1);
        chk("R1 irq", {irq_in, irq_out}, 0);
        chk("R1 bus_oe", bus_oe, 0);
        // R8 active mode address on select pins
        act_port_addr = 3'b101; #1;
        chk("R8 addr out", sel_out, 3'b101);
        chk("R8 all outputs", sel_oe, 3'b111);
        // R7 strobes ignored in active mode
        host_write(16'hdead, 0, 0);
        check_all();
        // R13 active output cycle drives out register
        core_wr(16'h1357);
        @(negedge clk); act_out_cycle = 1; #1;
        chk("R13 active drive oe", bus_oe, 1);
        chk("R13 active drive data", bus_out, 16'h1357);
        @(negedge clk); act_out_cycle = 0;
        // passive both, masks on
        pulse_cfg(16'h00c0);
        check_all();
        // R2 host write
        host_write(16'ha5c3, 0, 0);
        check_all();
        chk("R2 captured", core_in_data, 16'ha5c3);
        // R6 chip enable high ignored
        host_write(16'h0f0f, 1, 0);
        check_all();
        host_read(0, 1);
        check_all();
        // R10 ready flag = full | empty
        core_rd(); core_wr(16'h2222); check_all();
        chk("R10 ready low", sel_out[0], 0);
        // R5 status read does not set empty
        host_read(1, 0); check_all();
        chk("R5 empty kept", out_empty, 0);
        // R4 data read sets empty
        host_read(0, 0); check_all();
        // R12 long hold gives one event, ack clears
        do_ack(0);
        host_write(16'h7777, 0, 20); check_all();
        do_ack(0); check_all();
        chk("R12 ack clears", irq_in, 0);
        // R12 new event with simultaneous ack keeps pending
        host_write(16'h1111, 0, 0);
        @(negedge clk); bus_in = 16'h3333; in_strb_n = 0;
        @(negedge clk); @(negedge clk); ack_in = 1;
        @(negedge clk); ack_in = 0; m_in = 16'h3333;
        chk("R12 set beats ack", irq_in, 1);
        in_strb_n = 1; repeat (3) @(negedge clk);
        check_all();
        // R11 masks clear: no pending
        do_ack(0); do_ack(1);
        pulse_cfg(16'h0000);
        host_write(16'h4444, 0, 0); host_read(0, 0);
        check_all();
        chk("R11 masked", {irq_in, irq_out}, 0);
        // R9 mixed modes
        pulse_cfg(16'h1000); check_all();
        pulse_cfg(16'h0800); check_all();
        // random phase
        for (int i = 0; i < 300; i++) begin
            int op;
            op = $urandom_range(0, 6);
            act_port_addr = 3'($urandom);
            d = DW'($urandom);
            case (op)
                0: pulse_cfg(16'($urandom) & 16'h18c0 | (16'($urandom) & 16'h0300));
                1: host_write(d, ($urandom_range(0, 3) == 0), $urandom_range(0, 4));
                2: host_read(1'($urandom), ($urandom_range(0, 3) == 0));
                3: core_rd();
                4: core_wr(d);
                default: do_ack(1'($urandom));
            endcase
            check_all();
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule